// File: doc/BRIEF.md
# Prioritised Task Dispatcher

This block decides which of eight control tasks an execution engine runs next. A task is requested in one of two ways. Each task has a pair of hardware trigger lines and picks one of them. Software can also force requests with a bitmask. The dispatcher holds four bits per task: pending, enable, running and overflow. Whenever the engine is idle, it launches the lowest-numbered task that is both enabled and pending.

At launch, the dispatcher loads a 12-bit program-counter offset from a per-task vector table and raises a start pulse. The engine then runs the task to completion and signals the end with a stop strobe. The dispatcher answers the stop by clearing the running bit and pulsing a completion interrupt for that task. Instruction execution is outside the block. Software programs the enable mask, the source select mask and the clear masks through a small write port, and loads the vectors through a separate write port.

Top module: `task_dispatch`

## Requirements
- R1: After a synchronous reset, every state bit is zero: pending, enable, running, overflow and source select. `pc_o`, `start_o` and `done_irq_o` are also zero.
- R2: Bit i of the source register chooses the trigger for task i. A value of 0 selects `adc_trig[i]` and a value of 1 selects `alt_trig[i]`, where `alt_trig[N-1]` is the timer line. The line that is not selected has no effect on any state bit.
- R3: Each cycle in which the selected trigger is high sets the task's pending bit. If the pending bit was already set, and the task is not launched in that same cycle, the overflow bit is set as well.
- R4: A write to the force register (select code 1) sets the pending bit of every task whose mask bit is 1. For example, mask 0x03 flags tasks 0 and 1. A force write never sets an overflow bit.
- R5: When idle, the dispatcher picks the lowest index whose pending and enable bits are both 1. A pending task that is not enabled stays pending and is not launched.
- R6: At launch, the chosen task's pending bit clears, its running bit is set (at most one running bit at a time), `pc_o` takes that task's vector, and `start_o` is high for exactly one cycle, in the first cycle that the running bit is visible.
- R7: While a task runs, `run_o` and `pc_o` hold their values until `task_stop`. A `task_stop` that arrives while no task is running is ignored.
- R8: A `task_stop` that arrives while a task runs clears the running bit. In the next cycle, `done_irq_o` shows that task's bit for exactly one cycle.
- R9: Writes with select code 2 (pending clear) and code 3 (overflow clear) clear the bits that are 1 in the mask. If a new request sets the same bit in the same cycle, the request wins.
- R10: A completion pulse and a start pulse never share a cycle. At least one cycle with neither pulse separates a completion from the next launch.
- R11: A write with select code 0 replaces the enable mask. A write with select code 4 replaces the source mask. Other select codes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_trig | input | N_TASKS | Primary hardware trigger per task, high one cycle per request |
| alt_trig | input | N_TASKS | Alternate trigger per task; top bit is the timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 enable, 1 force, 2 pend clear, 3 ovf clear, 4 source |
| wr_data | input | N_TASKS | Register write mask |
| vec_we | input | 1 | Vector table write strobe |
| vec_idx | input | IDX_W | Vector table index |
| vec_wdata | input | VEC_W | Vector offset to store |
| task_stop | input | 1 | End-of-task strobe from the engine |
| pend_o | output | N_TASKS | Pending bits |
| en_o | output | N_TASKS | Enable bits |
| run_o | output | N_TASKS | Running bit, one-hot or zero |
| ovf_o | output | N_TASKS | Overflow bits |
| src_o | output | N_TASKS | Source select bits |
| pc_o | output | VEC_W | Program counter loaded at launch |
| start_o | output | 1 | One-cycle launch pulse |
| done_irq_o | output | N_TASKS | One-cycle completion interrupt per task |

## Verification
Every bit of state is exposed as a port, so a pending, enable or overflow bit that takes a wrong value shows up in the cycle right after the edge that wrote it. A wrong priority decision or a corrupt vector read shows up in `run_o` and `pc_o` in the launch cycle. A wrong completion sequence shows up within two cycles of the stop strobe. It appears either as a missing or misdirected `done_irq_o` bit, or as a start pulse that arrives before the required idle gap. The sweep drives every nonzero force mask, which exercises both the first launch and the follow-up launch of the next task.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_ENABLE = 3'd0,
    SEL_FORCE  = 3'd1,
    SEL_PCLR   = 3'd2,
    SEL_OCLR   = 3'd3,
    SEL_SRC    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/tdisp_trig_sel.sv
module tdisp_trig_sel #(
  parameter int N_TASKS = 8
) (
  input  logic [N_TASKS-1:0] src_sel,
  input  logic [N_TASKS-1:0] adc_trig,
  input  logic [N_TASKS-1:0] alt_trig,
  output logic [N_TASKS-1:0] hw_req
);
  // one two-way mux per task; R2
  for (genvar g = 0; g < N_TASKS; g++) begin : g_mux
    assign hw_req[g] = src_sel[g] ? alt_trig[g] : adc_trig[g];
  end
endmodule

// File: rtl/tdisp_prio.sv
module tdisp_prio #(
  parameter int N_TASKS = 8,
  parameter int IDX_W   = 3
) (
  input  logic [N_TASKS-1:0] req,
  output logic [N_TASKS-1:0] grant,
  output logic [IDX_W-1:0]   idx,
  output logic               valid
);
  // lowest index wins: scan from the top so the last hit is the lowest; R5
  always_comb begin
    grant = '0;
    idx   = '0;
    valid = 1'b0;
    for (int i = N_TASKS - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        valid    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdisp_vec_file.sv
module tdisp_vec_file #(
  parameter int N_TASKS = 8,
  parameter int VEC_W   = 12,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [VEC_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [VEC_W-1:0] rdata
);
  logic [VEC_W-1:0] mem [N_TASKS];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < N_TASKS)) mem[waddr] <= wdata;
  end

  // asynchronous read: distributed storage, the launch decision needs it at once
  assign rdata = mem[raddr];
endmodule

// File: rtl/task_dispatch.sv
module task_dispatch
  import tdisp_pkg::*;
#(
  parameter int N_TASKS = 8,
  parameter int VEC_W   = 12,
  parameter int IDX_W   = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TASKS-1:0] adc_trig,
  input  logic [N_TASKS-1:0] alt_trig,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [N_TASKS-1:0] wr_data,
  input  logic               vec_we,
  input  logic [IDX_W-1:0]   vec_idx,
  input  logic [VEC_W-1:0]   vec_wdata,
  input  logic               task_stop,
  output logic [N_TASKS-1:0] pend_o,
  output logic [N_TASKS-1:0] en_o,
  output logic [N_TASKS-1:0] run_o,
  output logic [N_TASKS-1:0] ovf_o,
  output logic [N_TASKS-1:0] src_o,
  output logic [VEC_W-1:0]   pc_o,
  output logic               start_o,
  output logic [N_TASKS-1:0] done_irq_o
);
  logic [N_TASKS-1:0] pend_q, en_q, run_q, ovf_q, src_q, done_q;
  logic [VEC_W-1:0]   pc_q;
  logic               start_q, cool_q;

  logic [N_TASKS-1:0] hw_req, sw_req, pclr, oclr, grant, launch_mask;
  logic [IDX_W-1:0]   gidx;
  logic               gvalid, launch, stop_ok;
  logic [VEC_W-1:0]   vec_rd;

  tdisp_trig_sel #(.N_TASKS(N_TASKS)) trig_i (
    .src_sel (src_q),
    .adc_trig(adc_trig),
    .alt_trig(alt_trig),
    .hw_req  (hw_req)
  );

  tdisp_prio #(.N_TASKS(N_TASKS), .IDX_W(IDX_W)) prio_i (
    .req  (pend_q & en_q),
    .grant(grant),
    .idx  (gidx),
    .valid(gvalid)
  );

  tdisp_vec_file #(.N_TASKS(N_TASKS), .VEC_W(VEC_W), .IDX_W(IDX_W)) vec_i (
    .clk  (clk),
    .we   (vec_we),
    .waddr(vec_idx),
    .wdata(vec_wdata),
    .raddr(gidx),
    .rdata(vec_rd)
  );

  // decoded register writes
  assign sw_req = (wr_en && wr_sel == SEL_FORCE) ? wr_data : '0;
  assign pclr   = (wr_en && wr_sel == SEL_PCLR)  ? wr_data : '0;
  assign oclr   = (wr_en && wr_sel == SEL_OCLR)  ? wr_data : '0;

  // launch only when idle and not in the cycle right after a stop (R10)
  assign launch      = gvalid && (run_q == '0) && !cool_q;
  assign launch_mask = launch ? grant : '0;
  assign stop_ok     = task_stop && (run_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      en_q    <= '0;
      run_q   <= '0;
      ovf_q   <= '0;
      src_q   <= '0;
      done_q  <= '0;
      pc_q    <= '0;
      start_q <= 1'b0;
      cool_q  <= 1'b0;
    end else begin
      // requests are OR'd in last so they beat a same-cycle clear (R9)
      pend_q  <= (pend_q & ~pclr & ~launch_mask) | hw_req | sw_req;
      ovf_q   <= (ovf_q & ~oclr) | (hw_req & pend_q & ~launch_mask);
      if (wr_en && wr_sel == SEL_ENABLE) en_q  <= wr_data;
      if (wr_en && wr_sel == SEL_SRC)    src_q <= wr_data;
      start_q <= launch;
      done_q  <= stop_ok ? run_q : '0;
      cool_q  <= stop_ok;
      if (launch) begin
        run_q <= grant;
        pc_q  <= vec_rd;
      end else if (stop_ok) begin
        run_q <= '0;
      end
    end
  end

  assign pend_o     = pend_q;
  assign en_o       = en_q;
  assign run_o      = run_q;
  assign ovf_o      = ovf_q;
  assign src_o      = src_q;
  assign pc_o       = pc_q;
  assign start_o    = start_q;
  assign done_irq_o = done_q;
endmodule

// File: rtl/task_dispatch_chk.sv
module task_dispatch_chk
  import tdisp_pkg::*;
#(
  parameter int N_TASKS = 8,
  parameter int VEC_W   = 12
) (
  input logic               clk,
  input logic               rst,
  input logic [N_TASKS-1:0] adc_trig,
  input logic [N_TASKS-1:0] alt_trig,
  input logic               wr_en,
  input logic [SEL_W-1:0]   wr_sel,
  input logic               task_stop,
  input logic [N_TASKS-1:0] run_o,
  input logic [N_TASKS-1:0] ovf_o,
  input logic [VEC_W-1:0]   pc_o,
  input logic               start_o,
  input logic [N_TASKS-1:0] done_irq_o
);
  AST_RUN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(run_o)); // R6
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_o |-> ($past(run_o) == '0 && run_o != '0)); // R6
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (run_o != '0 && !task_stop) |=> $stable(run_o)); // R7
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_o != '0 && !task_stop) |=> $stable(pc_o)); // R7
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (done_irq_o != '0) |-> ($past(task_stop) && $past(run_o) == done_irq_o)); // R8
  AST_SW_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_FORCE && adc_trig == '0 && alt_trig == '0) |=> $stable(ovf_o)); // R4
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(start_o && done_irq_o != '0)); // R10
  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (done_irq_o != '0) |=> !start_o); // R10
endmodule

bind task_dispatch task_dispatch_chk #(.N_TASKS(N_TASKS), .VEC_W(VEC_W)) chk_i (.*);

// File: tb/task_dispatch_tb_top.sv
module task_dispatch_tb_top;
  localparam int N = 8;
  localparam int VW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  adc_trig = '0, alt_trig = '0, wr_data = '0;
  logic          wr_en = 1'b0, vec_we = 1'b0, task_stop = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [2:0]    vec_idx = '0;
  logic [VW-1:0] vec_wdata = '0;
  logic [N-1:0]  pend_o, en_o, run_o, ovf_o, src_o, done_irq_o;
  logic [VW-1:0] pc_o;
  logic          start_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  task_dispatch #(.N_TASKS(N), .VEC_W(VW)) dut_i (
    .clk(clk), .rst(rst), .adc_trig(adc_trig), .alt_trig(alt_trig),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vec_we(vec_we), .vec_idx(vec_idx), .vec_wdata(vec_wdata),
    .task_stop(task_stop), .pend_o(pend_o), .en_o(en_o), .run_o(run_o),
    .ovf_o(ovf_o), .src_o(src_o), .pc_o(pc_o), .start_o(start_o),
    .done_irq_o(done_irq_o)
  );

  function automatic logic [VW-1:0] vexp(int i);
    return VW'(12'h0A0 + i * 37);
  endfunction

  function automatic logic [N-1:0] lowbit(logic [N-1:0] m);
    return m & (~m + 1'b1);
  endfunction

  function automatic int bidx(logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one cycle of inputs at the falling edge, return at the next falling edge
  task automatic step(logic we, logic [2:0] sel, logic [N-1:0] d,
                      logic [N-1:0] a, logic [N-1:0] t, logic s);
    wr_en = we; wr_sel = sel; wr_data = d;
    adc_trig = a; alt_trig = t; task_stop = s;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    adc_trig = '0; alt_trig = '0; task_stop = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 3'd0, '0, '0, '0, 1'b0);
  endtask

  task automatic wreg(logic [2:0] sel, logic [N-1:0] d);
    step(1'b1, sel, d, '0, '0, 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [N-1:0] lb, rem;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", "pend", 32'(pend_o), 0);
    chk("R1", "en",   32'(en_o),   0);
    chk("R1", "run",  32'(run_o),  0);
    chk("R1", "ovf",  32'(ovf_o),  0);
    chk("R1", "src",  32'(src_o),  0);
    chk("R1", "pc",   32'(pc_o),   0);
    chk("R1", "start", 32'(start_o), 0);
    chk("R1", "done", 32'(done_irq_o), 0);

    for (int i = 0; i < N; i++) begin
      vec_we = 1'b1; vec_idx = 3'(i); vec_wdata = vexp(i);
      @(posedge clk); @(negedge clk);
    end
    vec_we = 1'b0;

    // R11 register writes, unused code
    wreg(3'd0, 8'h5A);
    chk("R11", "enable write", 32'(en_o), 32'h5A);
    wreg(3'd6, 8'hFF);
    chk("R11", "bad code en", 32'(en_o), 32'h5A);
    chk("R11", "bad code pend", 32'(pend_o), 0);
    wreg(3'd0, 8'h00);

    // R2 source selection, R3 overflow
    step(1'b0, 3'd0, '0, '0, 8'hFF, 1'b0);
    chk("R2", "unselected alt ignored", 32'(pend_o), 0);
    step(1'b0, 3'd0, '0, 8'h05, '0, 1'b0);
    chk("R3", "hw sets pend", 32'(pend_o), 32'h05);
    chk("R3", "no ovf yet", 32'(ovf_o), 0);
    step(1'b0, 3'd0, '0, 8'h05, '0, 1'b0);
    chk("R3", "repeat sets ovf", 32'(ovf_o), 32'h05);
    chk("R3", "pend kept", 32'(pend_o), 32'h05);
    wreg(3'd4, 8'hF0);
    chk("R11", "src write", 32'(src_o), 32'hF0);
    step(1'b0, 3'd0, '0, 8'hFF, '0, 1'b0);
    chk("R2", "adc only low half", 32'(pend_o), 32'h0F);
    chk("R3", "ovf after mixed", 32'(ovf_o), 32'h05);
    step(1'b0, 3'd0, '0, '0, 8'h80, 1'b0);
    chk("R2", "timer line task7", 32'(pend_o), 32'h8F);
    wreg(3'd1, 8'hFF);
    chk("R4", "force pend", 32'(pend_o), 32'hFF);
    chk("R4", "force no ovf", 32'(ovf_o), 32'h05);
    wreg(3'd3, 8'h01);
    chk("R9", "ovf W1C", 32'(ovf_o), 32'h04);
    step(1'b1, 3'd2, 8'h0F, 8'h01, '0, 1'b0);
    chk("R9", "pend clear vs request", 32'(pend_o), 32'hF1);
    chk("R3", "ovf from kept pend", 32'(ovf_o), 32'h05);
    step(1'b1, 3'd3, 8'h01, 8'h01, '0, 1'b0);
    chk("R9", "ovf clear vs overflow", 32'(ovf_o), 32'h05);
    step(1'b0, 3'd0, '0, '0, '0, 1'b1);
    idle();
    chk("R7", "stop while idle", 32'(done_irq_o), 0);
    chk("R5", "disabled not launched", 32'(run_o), 0);
    wreg(3'd4, 8'h00);

    // sweep every nonzero force mask: priority, launch, stop, follow-up
    for (int m = 1; m < (1 << N); m++) begin
      wreg(3'd0, 8'h00);
      wreg(3'd2, 8'hFF);
      wreg(3'd3, 8'hFF);
      wreg(3'd1, N'(m));
      chk("R4", "force mask", 32'(pend_o), 32'(m));
      chk("R4", "force keeps ovf clear", 32'(ovf_o), 0);
      wreg(3'd0, 8'hFF);
      idle();
      lb = lowbit(N'(m));
      chk("R5", "winner", 32'(run_o), 32'(lb));
      chk("R6", "start pulse", 32'(start_o), 1);
      chk("R6", "pc vector", 32'(pc_o), 32'(vexp(bidx(lb))));
      chk("R6", "pend cleared", 32'(pend_o), 32'(N'(m) & ~lb));
      idle();
      chk("R6", "start one cycle", 32'(start_o), 0);
      chk("R7", "run held", 32'(run_o), 32'(lb));
      chk("R7", "pc held", 32'(pc_o), 32'(vexp(bidx(lb))));
      step(1'b0, 3'd0, '0, '0, '0, 1'b1);
      chk("R8", "done pulse", 32'(done_irq_o), 32'(lb));
      chk("R8", "run cleared", 32'(run_o), 0);
      idle();
      chk("R8", "done one cycle", 32'(done_irq_o), 0);
      chk("R10", "no start in gap", 32'(start_o), 0);
      idle();
      rem = N'(m) & ~lb;
      if (rem != '0) begin
        chk("R10", "next start", 32'(start_o), 1);
        chk("R5", "next winner", 32'(run_o), 32'(lowbit(rem)));
      end else begin
        chk("R5", "nothing left", 32'(run_o), 0);
      end
      wreg(3'd0, 8'h00);
      if (run_o != '0) step(1'b0, 3'd0, '0, '0, '0, 1'b1);
      idle();
      idle();
    end

    finish_run();
  end
endmodule